// File: doc/BRIEF.md
# Synchronized Edge Timestamp Capture

This block records when an asynchronous pulse rises and when it falls. It measures both moments against a free-running counter that shares the block's single system clock. The pulse first passes through a chain of flip-flops clocked by the system clock, which brings it into the clock domain. A registered comparison of the synchronized level with its value one cycle earlier then finds the two transitions. The counter value is latched into a start stamp on each rising transition and into a stop stamp on each falling transition. Each latch raises its own one-cycle valid strobe.

No register in the block is clocked by the pulse. The synchronizer makes every stamp lag the true input edge by a fixed number of cycles. A build-time switch can subtract this lag from the stamp before it is stored, with wrap-around, so that the stamp reads the counter value that was current when the input changed. The difference between the stop stamp and the start stamp gives the pulse width in clock cycles. Computing that difference is left to the consumer.

Top module: `edge_stamp_top`

## Requirements
- R1: With correction off, a stamp equals (V + 2) mod 1024, where V is the counter value while the input changed. The offset of 2 comes from the two synchronizer stages.
- R2: The counter starts at 0 after reset, advances by one on every clock and wraps from 1023 to 0. Stamps taken across the wrap reflect this.
- R3: A low-to-high change of the input pulses `start_valid` and updates `start_stamp`. The stop outputs are left unchanged.
- R4: A high-to-low change of the input pulses `stop_valid` and updates `stop_stamp`. The start outputs are left unchanged.
- R5: While `rst` is high at a clock edge, both stamps, both strobes and the counter are cleared to 0.
- R6: Each strobe is high for exactly one cycle. It is asserted after the third rising clock edge that follows the input change.
- R7: Between captures, a stamp holds its value. A new edge of the same polarity overwrites it.
- R8: With correction on, a stamp equals V itself, computed modulo 1024. For example, a rise at V = 1023 gives a start stamp of 1023, and a fall at V = 0 gives a stop stamp of 0.
- R9: If the input stays low through reset and after its release, no strobe appears after reset.
- R10: For a pulse held high for w clock cycles, where w can be as small as 1, `stop_stamp - start_stamp` equals w modulo 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Asynchronous pulse to timestamp |
| start_stamp | output | CNT_W | Counter value captured on the last rising transition |
| start_valid | output | 1 | One-cycle strobe when `start_stamp` updates |
| stop_stamp | output | CNT_W | Counter value captured on the last falling transition |
| stop_valid | output | 1 | One-cycle strobe when `stop_stamp` updates |

## Verification
The bench instantiates the block twice, both with CNT_W = 10 and SYNC_STAGES = 2. One instance has correction off and the other has it on, so the bench compares the raw lag and the corrected stamp on the same stimulus. The 10-bit counter wraps every 1024 cycles, so a sweep of all pulse widths from 1 to 5 against several low gaps passes through the wrap several times. A targeted pulse at count 1023 makes the corrected subtraction go below zero. A reset in the middle of the sweep confirms that the counter restarts and that no stray strobe appears.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

  // Polarity of the transition a capture channel listens to.
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  // Cycles between an input change and the counter value that gets latched:
  // one per synchronizer stage.
  function automatic int stamp_lag(input int stages);
    return stages;
  endfunction

endpackage

// File: rtl/edge_stamp_sync.sv
module edge_stamp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/edge_stamp_edges.sv
module edge_stamp_edges (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= level;
    end
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

endmodule

// File: rtl/edge_stamp_counter.sv
module edge_stamp_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count
);

  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture #(
  parameter int           W        = 10,
  parameter logic [W-1:0] SUBTRACT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  input  logic [W-1:0] count,
  output logic [W-1:0] stamp,
  output logic         valid
);

  logic [W-1:0] stamp_q;
  logic         valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= hit;
      if (hit) begin
        stamp_q <= count - SUBTRACT;
      end
    end
  end

  assign stamp = stamp_q;
  assign valid = valid_q;

endmodule

// File: rtl/edge_stamp_top.sv
module edge_stamp_top #(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter bit FIX_LATENCY = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_in,
  output logic [CNT_W-1:0] start_stamp,
  output logic             start_valid,
  output logic [CNT_W-1:0] stop_stamp,
  output logic             stop_valid
);
  import edge_stamp_pkg::*;

  localparam int               LAG  = stamp_lag(SYNC_STAGES);
  localparam logic [CNT_W-1:0] CORR = FIX_LATENCY ? CNT_W'(LAG) : '0;
  localparam int               NCH  = 2;

  logic             level_sync;
  logic             rise_hit;
  logic             fall_hit;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] ch_stamp [NCH];
  logic             ch_valid [NCH];

  edge_stamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pulse_in),
    .sync_out (level_sync)
  );

  edge_stamp_edges u_edges (
    .clk   (clk),
    .rst   (rst),
    .level (level_sync),
    .rise  (rise_hit),
    .fall  (fall_hit)
  );

  edge_stamp_counter #(.W(CNT_W)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .count (count_q)
  );

  // One capture channel per polarity.
  for (genvar k = 0; k < NCH; k++) begin : g_chan
    localparam edge_kind_e KIND = edge_kind_e'(k);
    logic hit_sel;
    assign hit_sel = (KIND == EDGE_RISE) ? rise_hit : fall_hit;

    edge_stamp_capture #(.W(CNT_W), .SUBTRACT(CORR)) u_cap (
      .clk   (clk),
      .rst   (rst),
      .hit   (hit_sel),
      .count (count_q),
      .stamp (ch_stamp[k]),
      .valid (ch_valid[k])
    );
  end

  assign start_stamp = ch_stamp[EDGE_RISE];
  assign start_valid = ch_valid[EDGE_RISE];
  assign stop_stamp  = ch_stamp[EDGE_FALL];
  assign stop_valid  = ch_valid[EDGE_FALL];

endmodule

// File: rtl/edge_stamp_checks.sv
module edge_stamp_checks #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] start_stamp,
  input logic         start_valid,
  input logic [W-1:0] stop_stamp,
  input logic         stop_valid,
  input logic [W-1:0] count_now
);

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> count_now == $past(count_now) + 1'b1);

  p_reset_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (start_stamp == '0 && stop_stamp == '0 && count_now == '0));

  p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!start_valid && !stop_valid));

  p_start_single_r6: assert property (@(posedge clk) disable iff (rst)
    start_valid |=> !start_valid);

  p_stop_single_r6: assert property (@(posedge clk) disable iff (rst)
    stop_valid |=> !stop_valid);

  p_start_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!start_valid && !$past(rst)) |-> $stable(start_stamp));

  p_stop_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!stop_valid && !$past(rst)) |-> $stable(stop_stamp));

  p_one_polarity_r3: assert property (@(posedge clk) disable iff (rst)
    !(start_valid && stop_valid));

endmodule

bind edge_stamp_top edge_stamp_checks #(.W(CNT_W)) u_checks (
  .clk         (clk),
  .rst         (rst),
  .start_stamp (start_stamp),
  .start_valid (start_valid),
  .stop_stamp  (stop_stamp),
  .stop_valid  (stop_valid),
  .count_now   (count_q)
);

// File: tb/edge_stamp_top_tb_top.sv
`timescale 1ns/1ps
module edge_stamp_top_tb_top;

  localparam int W   = 10;
  localparam int LAG = 2;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0;

  // index 0: correction off, index 1: correction on
  logic [W-1:0] st_stamp [2];
  logic [W-1:0] sp_stamp [2];
  logic         st_valid [2];
  logic         sp_valid [2];

  always #2.5 clk = ~clk;

  edge_stamp_top #(.CNT_W(W), .SYNC_STAGES(LAG), .FIX_LATENCY(1'b0)) dut_i (
    .clk(clk), .rst(rst), .pulse_in(pulse_in),
    .start_stamp(st_stamp[0]), .start_valid(st_valid[0]),
    .stop_stamp(sp_stamp[0]), .stop_valid(sp_valid[0])
  );

  edge_stamp_top #(.CNT_W(W), .SYNC_STAGES(LAG), .FIX_LATENCY(1'b1)) dut_fix_i (
    .clk(clk), .rst(rst), .pulse_in(pulse_in),
    .start_stamp(st_stamp[1]), .start_valid(st_valid[1]),
    .stop_stamp(sp_stamp[1]), .stop_valid(sp_valid[1])
  );

  int checks = 0;
  int fails  = 0;

  // Bench model of the counter and a cycle index, from R2 and R5.
  int model_cnt = 0;
  int cyc = 0;
  always @(posedge clk) begin
    model_cnt <= rst ? 0 : (model_cnt + 1) % MOD;
    cyc       <= cyc + 1;
  end

  // Expected strobes, keyed by the cycle in which they must appear.
  bit due_rise [16];
  bit due_fall [16];
  int due_val  [16];
  int exp_start [2];
  int exp_stop  [2];
  int since_rst = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Monitor: sample 1 ns after each rising edge.
  always begin
    int idx;
    int expv;
    string vtag;
    @(posedge clk);
    #1;
    if (rst) begin
      for (int i = 0; i < 16; i++) begin
        due_rise[i] = 1'b0;
        due_fall[i] = 1'b0;
      end
      for (int d = 0; d < 2; d++) begin
        exp_start[d] = 0;
        exp_stop[d]  = 0;
        check("R5 start_stamp in reset", int'(st_stamp[d]), 0);
        check("R5 stop_stamp in reset", int'(sp_stamp[d]), 0);
        check("R5 start_valid in reset", int'(st_valid[d]), 0);
        check("R5 stop_valid in reset", int'(sp_valid[d]), 0);
      end
      since_rst = 0;
    end else begin
      idx = cyc % 16;
      since_rst++;
      for (int d = 0; d < 2; d++) begin
        expv = (d == 1) ? due_val[idx] : (due_val[idx] + LAG) % MOD;
        vtag = (d == 1) ? "R8 R2" : "R1 R2";
        check(since_rst <= 3 ? "R9 start_valid after reset" : "R3 R6 start_valid",
              int'(st_valid[d]), int'(due_rise[idx]));
        check(since_rst <= 3 ? "R9 stop_valid after reset" : "R4 R6 stop_valid",
              int'(sp_valid[d]), int'(due_fall[idx]));
        if (due_rise[idx]) begin
          exp_start[d] = expv;
          check({vtag, " start_stamp"}, int'(st_stamp[d]), expv);
        end else begin
          check("R7 R4 start_stamp held", int'(st_stamp[d]), exp_start[d]);
        end
        if (due_fall[idx]) begin
          exp_stop[d] = expv;
          check({vtag, " stop_stamp"}, int'(sp_stamp[d]), expv);
        end else begin
          check("R7 R3 stop_stamp held", int'(sp_stamp[d]), exp_stop[d]);
        end
      end
      due_rise[idx] = 1'b0;
      due_fall[idx] = 1'b0;
    end
  end

  // Called right after a falling clock edge; the strobe is due three rising edges later (R6).
  task automatic set_level(input bit b);
    int slot;
    if (b != pulse_in) begin
      slot = (cyc + 3) % 16;
      if (b) due_rise[slot] = 1'b1;
      else   due_fall[slot] = 1'b1;
      due_val[slot] = model_cnt;
    end
    pulse_in = b;
  endtask

  task automatic pulse(input int w, input int l);
    @(negedge clk);
    set_level(1'b1);
    repeat (w) @(negedge clk);
    set_level(1'b0);
    repeat (3) @(negedge clk);
    // R10: the difference between stamps gives the width in cycles
    for (int d = 0; d < 2; d++) begin
      check($sformatf("R10 width w=%0d", w),
            (int'(sp_stamp[d]) - int'(st_stamp[d]) + MOD) % MOD, w);
    end
    repeat (l) @(negedge clk);
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: input held low, so no strobe appears after reset
    repeat (8) @(negedge clk);
    for (int rep = 0; rep < 12; rep++) begin
      if (rep == 5) begin
        repeat (4) @(negedge clk);
        do_reset(3);
        repeat (4) @(negedge clk);
      end
      for (int w = 1; w <= 5; w++) begin
        for (int l = 0; l < 5; l++) begin
          pulse(w, l);
        end
      end
    end
    // R8: rise at count 1023 and fall at count 0 push the correction below zero
    while (model_cnt != MOD - 2) @(negedge clk);
    pulse(1, 3);
    check("R8 start_stamp at 1023", int'(st_stamp[1]), MOD - 1);
    check("R8 stop_stamp at 0", int'(sp_stamp[1]), 0);
    check("R1 R2 start_stamp wrapped", int'(st_stamp[0]), 1);
    repeat (6) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule